// File: doc/BRIEF.md
# Redundant Timing Role Sequencer

This block decides the role of one device in a pair of redundant timing sources. A device is designated either master or slave. At any time only one device of the pair drives the output clocks, including the frame and multiframe clocks, and performs reference switching and priority table building. The sequencer drives a registered `drive_en` flag that enables that work, and a two-bit role code for observation.

A slave stays in standby while its partner is healthy and becomes active when it sees the partner fail. A master that has been repaired and put back into service must not cause phase hits. It therefore comes up subordinate to the active slave. It only takes control back once it is aligned to the partner's frame clocks and priority table, and once an explicit restore command arrives. The slave then returns to standby one cycle after the partner-failure indication clears.

For a master, `peer_fail` means the partner reports that it has taken control. On the master side, a rising edge of this input, or the input being high during reset, sends the master to the subordinate role.

Top module: `redund_role_ctl`

## Requirements
- R1: While `rst_n` is low, the role is latched on each clock edge from `cfg_is_master`. With `cfg_is_master`=1 and `peer_fail`=0 the role is MASTER_ACTIVE (code 0) and `drive_en`=1. With `cfg_is_master`=0 the role is SLAVE_STANDBY (code 1) and `drive_en`=0.
- R2: A master held in reset while `peer_fail`=1 comes out in MASTER_SUBORDINATE (code 3) with `drive_en`=0.
- R3: In SLAVE_STANDBY, `peer_fail`=1 at a clock edge gives SLAVE_ACTIVE (code 2) with `drive_en`=1 after that edge.
- R4: In SLAVE_ACTIVE, `peer_fail`=0 at a clock edge returns the device to SLAVE_STANDBY with `drive_en`=0 after that edge.
- R5: In MASTER_ACTIVE, a rising edge of `peer_fail` (high now, low at the previous edge) gives MASTER_SUBORDINATE with `drive_en`=0 after that edge.
- R6: In MASTER_SUBORDINATE, `restore_req`=1 with both `frame_locked`=1 and `table_synced`=1 gives MASTER_ACTIVE with `drive_en`=1 after that edge.
- R7: In MASTER_SUBORDINATE, `restore_req` is ignored while either alignment flag is low, and no state change occurs. Without `restore_req` the role also stays put.
- R8: `drive_en` is a register output. It is 1 exactly in codes 0 and 2, and it changes only on the edge where the role changes.
- R9: Outside reset, changes of `cfg_is_master` have no effect. A master-side role (0 or 3) never becomes a slave-side role (1 or 2), and the reverse also holds.
- R10: A master restored to MASTER_ACTIVE while `peer_fail` is still high stays active until a new rising edge of `peer_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_is_master | input | 1 | Designation: 1 master, 0 slave; sampled only in reset |
| peer_fail | input | 1 | Partner failed (slave side) / partner holds control (master side) |
| frame_locked | input | 1 | Aligned to partner frame and multiframe clocks |
| table_synced | input | 1 | Priority table copied from partner |
| restore_req | input | 1 | Switch-back command |
| drive_en | output | 1 | Enables output clock drivers and reference switching |
| role | output | 2 | Role code: 0 master active, 1 slave standby, 2 slave active, 3 master subordinate |

## Verification
The bench sends restore commands with only one alignment flag set. A sequencer that checked a single flag would hand control back early and cause a phase hit. It holds `peer_fail` high across a restore, so a master that reacts to the level instead of the edge would drop straight back to subordinate. It brings a master out of reset with the partner still in control, where a faulty design would drive the outputs for a cycle. It also toggles the designation input outside reset, which a design that samples it continuously would follow, swapping to the wrong side.

// File: rtl/redund_role_pkg.sv
package redund_role_pkg;

   localparam int ROLE_W = 2;

   typedef enum logic [ROLE_W-1:0] {
      ROLE_MSTR_ACT = 2'd0,
      ROLE_SLV_STBY = 2'd1,
      ROLE_SLV_ACT  = 2'd2,
      ROLE_MSTR_SUB = 2'd3
   } role_e;

   function automatic logic role_drives(input role_e r);
      return (r == ROLE_MSTR_ACT) || (r == ROLE_SLV_ACT);
   endfunction

endpackage

// File: rtl/redund_role_next.sv
module redund_role_next
   import redund_role_pkg::*;
(
   input  role_e cur,
   input  logic  peer_down,
   input  logic  peer_rise,
   input  logic  frm_ok,
   input  logic  tbl_ok,
   input  logic  restore,
   output role_e nxt
);
   logic aligned;
   assign aligned = frm_ok & tbl_ok;

   always_comb begin
      nxt = cur;
      unique case (cur)
         ROLE_MSTR_ACT: if (peer_rise)           nxt = ROLE_MSTR_SUB;
         ROLE_MSTR_SUB: if (restore && aligned)  nxt = ROLE_MSTR_ACT;
         ROLE_SLV_STBY: if (peer_down)           nxt = ROLE_SLV_ACT;
         ROLE_SLV_ACT:  if (!peer_down)          nxt = ROLE_SLV_STBY;
         default:                                nxt = cur;
      endcase
   end
endmodule

// File: rtl/redund_role_reg.sv
module redund_role_reg
   import redund_role_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  role_e boot_role,
   input  role_e nxt,
   output role_e cur,
   output logic  drive
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= boot_role;
         drive <= role_drives(boot_role);
      end else begin
         cur   <= nxt;
         drive <= role_drives(nxt);
      end
   end
endmodule

// File: rtl/redund_role_ctl.sv
module redund_role_ctl
   import redund_role_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_is_master,
   input  logic              peer_fail,
   input  logic              frame_locked,
   input  logic              table_synced,
   input  logic              restore_req,
   output logic              drive_en,
   output logic [ROLE_W-1:0] role
);
   role_e cur_role, nxt_role, boot_role;
   logic  peer_q;
   logic  peer_rise;

   // Previous partner flag; loaded during reset so no false edge follows.
   always_ff @(posedge clk) begin
      peer_q <= peer_fail;
   end

   assign peer_rise = peer_fail & ~peer_q;

   always_comb begin
      if (!cfg_is_master)  boot_role = ROLE_SLV_STBY;
      else if (peer_fail)  boot_role = ROLE_MSTR_SUB;
      else                 boot_role = ROLE_MSTR_ACT;
   end

   redund_role_next u_next (
      .cur       (cur_role),
      .peer_down (peer_fail),
      .peer_rise (peer_rise),
      .frm_ok    (frame_locked),
      .tbl_ok    (table_synced),
      .restore   (restore_req),
      .nxt       (nxt_role)
   );

   redund_role_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_role (boot_role),
      .nxt       (nxt_role),
      .cur       (cur_role),
      .drive     (drive_en)
   );

   assign role = cur_role;
endmodule

// File: rtl/redund_role_chk.sv
module redund_role_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       peer_fail,
   input logic       frame_locked,
   input logic       table_synced,
   input logic       restore_req,
   input logic       drive_en,
   input logic [1:0] role
);
   a_r3_slave_takes_over: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd1 && peer_fail) |=> (role == 2'd2 && drive_en));

   a_r4_slave_stands_down: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd2 && !peer_fail) |=> (role == 2'd1 && !drive_en));

   a_r6_restore_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd3 && restore_req && frame_locked && table_synced) |=> (role == 2'd0));

   a_r7_restore_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd3 && !(restore_req && frame_locked && table_synced)) |=> (role == 2'd3));

   a_r8_drive_matches_role: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en == (role == 2'd0 || role == 2'd2));

   a_r8_drive_moves_with_role: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drive_en) |-> !$stable(role));

   a_r9_master_side_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd0 || role == 2'd3) |=> (role == 2'd0 || role == 2'd3));

   a_r9_slave_side_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (role == 2'd1 || role == 2'd2) |=> (role == 2'd1 || role == 2'd2));
endmodule

bind redund_role_ctl redund_role_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .peer_fail    (peer_fail),
   .frame_locked (frame_locked),
   .table_synced (table_synced),
   .restore_req  (restore_req),
   .drive_en     (drive_en),
   .role         (role)
);

// File: tb/redund_role_ctl_tb.sv
module redund_role_ctl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_is_master = 1'b1;
   logic       peer_fail = 1'b0;
   logic       frame_locked = 1'b0;
   logic       table_synced = 1'b0;
   logic       restore_req = 1'b0;
   logic       drive_en;
   logic [1:0] role;

   int n_checks = 0;
   int n_errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   redund_role_ctl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_is_master (cfg_is_master),
      .peer_fail     (peer_fail),
      .frame_locked  (frame_locked),
      .table_synced  (table_synced),
      .restore_req   (restore_req),
      .drive_en      (drive_en),
      .role          (role)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, cycles=%0d expected<=5000", cycles);
         report();
      end
   end

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic expect_role(input string tag, input logic [1:0] exp_role, input logic exp_drv);
      n_checks++;
      if (role !== exp_role || drive_en !== exp_drv) begin
         n_errors++;
         $display("FAIL %s: role=%0d drive_en=%b expected role=%0d drive_en=%b",
                  tag, role, drive_en, exp_role, exp_drv);
      end
   endtask

   task automatic do_reset(input logic master, input logic pf);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_is_master = master;
      peer_fail = pf;
      frame_locked = 1'b0;
      table_synced = 1'b0;
      restore_req = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic t_master_boot();
      do_reset(1'b1, 1'b0);
      expect_role("R1 master boot", 2'd0, 1'b1);
      tick(2);
      expect_role("R1/R8 master idle", 2'd0, 1'b1);
   endtask

   task automatic t_designation_ignored();
      cfg_is_master = 1'b0;
      tick(3);
      expect_role("R9 designation flip in master", 2'd0, 1'b1);
      cfg_is_master = 1'b1;
   endtask

   task automatic t_master_yields();
      peer_fail = 1'b1;
      tick(1);
      expect_role("R5/R8 master yields on partner edge", 2'd3, 1'b0);
      tick(2);
      expect_role("R5 stays subordinate", 2'd3, 1'b0);
   endtask

   task automatic t_restore_refused();
      frame_locked = 1'b1; table_synced = 1'b0; restore_req = 1'b1;
      tick(1);
      expect_role("R7 restore with table unsynced", 2'd3, 1'b0);
      frame_locked = 1'b0; table_synced = 1'b1;
      tick(1);
      expect_role("R7 restore with frame unlocked", 2'd3, 1'b0);
      frame_locked = 1'b1; restore_req = 1'b0;
      tick(2);
      expect_role("R7 aligned without restore", 2'd3, 1'b0);
   endtask

   task automatic t_restore_granted();
      restore_req = 1'b1;
      tick(1);
      restore_req = 1'b0;
      expect_role("R6/R8 restore granted", 2'd0, 1'b1);
      tick(3);
      expect_role("R10 partner flag still high", 2'd0, 1'b1);
      peer_fail = 1'b0;
      tick(1);
      peer_fail = 1'b1;
      tick(1);
      expect_role("R5 second partner edge", 2'd3, 1'b0);
   endtask

   task automatic t_master_boot_subordinate();
      do_reset(1'b1, 1'b1);
      expect_role("R2 repaired master boots subordinate", 2'd3, 1'b0);
      tick(2);
      expect_role("R2 no edge at release", 2'd3, 1'b0);
   endtask

   task automatic t_slave_cycle();
      do_reset(1'b0, 1'b0);
      expect_role("R1 slave boot", 2'd1, 1'b0);
      restore_req = 1'b1; frame_locked = 1'b1; table_synced = 1'b1;
      cfg_is_master = 1'b1;
      tick(2);
      restore_req = 1'b0;
      expect_role("R9 slave ignores designation and restore", 2'd1, 1'b0);
      peer_fail = 1'b1;
      tick(1);
      expect_role("R3/R8 slave takes over", 2'd2, 1'b1);
      tick(3);
      expect_role("R3 slave holds", 2'd2, 1'b1);
      peer_fail = 1'b0;
      tick(1);
      expect_role("R4/R8 slave back to standby", 2'd1, 1'b0);
   endtask

   initial begin
      tick(2);
      t_master_boot();
      t_designation_ignored();
      t_master_yields();
      t_restore_refused();
      t_restore_granted();
      t_master_boot_subordinate();
      t_slave_cycle();
      report();
   end
endmodule